// File: doc/BRIEF.md
# Condition-Code Register and Interrupt Mask Controller

This block holds the eight condition-code flags of an 8-bit processor and decides which interrupts the sequencer may take. Arithmetic results reach it on update strobes. An add-type operation supplies its two operands and carry-in, and the block derives the half-carry flag from them itself. Software changes the register in two ways: a transfer-from-accumulator write, and a restore of a stacked copy on return-from-interrupt.

The block also owns three mask bits. The global maskable mask blocks ordinary requests. The pin-request mask blocks the high-priority pin interrupt. The stop-disable bit makes a decoded STOP act as a no-op. Hardware can set the pin mask, but no software path can ever set it again. Software can only clear it. When the sequencer reports that stacking has finished for an accepted interrupt, the block raises the mask bits before the vector fetch starts.

Top module: `ccr_ctrl`

## Requirements
- R1: A synchronous reset sets S (bit 7), X (bit 6) and I (bit 4) to 1 and clears H, N, Z, V and C, so `ccr_q` reads 0xD0.
- R2: `take_irq` is 1 only when `irq_pend` is 1, I is 0 and `take_xirq` is 0. While I is 1 a pending request is never taken.
- R3: On a cycle with `ack_valid` = 1, I reads 1 from the next cycle onward.
- R4: On a cycle with `ack_valid` = 1 and `ack_pin` = 1, both X and I read 1 from the next cycle onward.
- R5: Neither a transfer write nor a restore can change X from 0 to 1. Writing 0xFF while X is 0 leaves X at 0.
- R6: A transfer write (`tap_we`) loads bits 7, 5, 4, 3, 2, 1, 0 from `tap_data`. It clears X when `tap_data[6]` is 0 and otherwise leaves X unchanged.
- R7: A restore (`rti_we`) loads the register from `rti_data` by the same rule as R6.
- R8: On `add_op`, H becomes 1 if `add_a[3:0] + add_b[3:0] + add_cin` exceeds 15, and becomes 0 otherwise.
- R9: On `alu_upd`, N, Z, V and C (bits 3..0) take `alu_nzvc[3:0]` in that order.
- R10: `take_xirq` equals `xirq_pend` when X is 0, whatever the value of I. It has priority over a maskable request in the same cycle.
- R11: `stop_ok` equals `stop_dec` when S is 0. It is 0 whenever S is 1.
- R12: When writes coincide, a restore wins over a transfer write, and a transfer write wins over the ALU and add strobes. An acknowledge still sets I (and X) in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_upd | input | 1 | Load N, Z, V, C from the ALU |
| alu_nzvc | input | 4 | ALU flags N, Z, V, C |
| add_op | input | 1 | Add-type operation, update H |
| add_a | input | 8 | First add operand |
| add_b | input | 8 | Second add operand |
| add_cin | input | 1 | Carry into the add |
| tap_we | input | 1 | Transfer-from-accumulator write |
| tap_data | input | 8 | Value written by the transfer |
| rti_we | input | 1 | Restore from stack |
| rti_data | input | 8 | Stacked register value |
| irq_pend | input | 1 | Maskable request pending |
| xirq_pend | input | 1 | Pin request pending |
| ack_valid | input | 1 | Stacking done for accepted interrupt |
| ack_pin | input | 1 | Accepted interrupt is the pin request |
| stop_dec | input | 1 | STOP instruction decoded |
| ccr_q | output | 8 | Condition-code register |
| take_irq | output | 1 | Take maskable interrupt |
| take_xirq | output | 1 | Take pin interrupt |
| stop_ok | output | 1 | STOP may enter low-power state |

## Verification
The bench sweeps every transfer value from reset and then writes 0xFF over the result. A design that let software set X would show bit 6 high after a value with bit 6 clear. The half-carry sweep covers every pair of low nibbles with both carry-in values. An off-by-one threshold, or a carry-in left out, would give the wrong H at exactly 15 and 16. Every combination of the two masks and the two requests is applied. A design that gated the pin request with I, or let both takes rise together, would fail there. Coincident strobes check the write priority and show whether an acknowledge is lost under a concurrent write.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int CCR_W  = 8;
    localparam int OPND_W = 8;
    localparam int NIB_W  = OPND_W / 2;
    localparam int FLAG_W = 4;

    typedef struct packed {
        logic s;
        logic x;
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ALU  = 2'd1,
        SRC_TAP  = 2'd2,
        SRC_RTI  = 2'd3
    } wsrc_e;

    localparam ccr_t CCR_RESET = '{s: 1'b1, x: 1'b1, h: 1'b0, i: 1'b1,
                                   n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

    function automatic logic nib_carry(input logic [NIB_W-1:0] a,
                                       input logic [NIB_W-1:0] b,
                                       input logic cin);
        logic [NIB_W:0] sum;
        sum = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
        return sum[NIB_W];
    endfunction
endpackage

// File: rtl/ccr_flags.sv
module ccr_flags
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wsrc_e             src,
    input  logic              add_op,
    input  logic [OPND_W-1:0] add_a,
    input  logic [OPND_W-1:0] add_b,
    input  logic              add_cin,
    input  logic              alu_upd,
    input  logic [FLAG_W-1:0] alu_nzvc,
    input  logic [CCR_W-1:0]  sw_data,
    output logic              h_q,
    output logic [FLAG_W-1:0] nzvc_q
);
    logic hc;
    assign hc = nib_carry(add_a[NIB_W-1:0], add_b[NIB_W-1:0], add_cin);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q    <= CCR_RESET.h;
            nzvc_q <= '0;
        end else if (src == SRC_TAP || src == SRC_RTI) begin
            h_q    <= sw_data[5];
            nzvc_q <= sw_data[FLAG_W-1:0];
        end else begin
            if (add_op)  h_q    <= hc;
            if (alu_upd) nzvc_q <= alu_nzvc;
        end
    end

    // R8
    hc_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (add_op && !(src == SRC_TAP || src == SRC_RTI)) |=> (h_q == $past(hc)));
endmodule

// File: rtl/ccr_mask.sv
module ccr_mask
    import ccr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wsrc_e            src,
    input  logic [CCR_W-1:0] sw_data,
    input  logic             ack_valid,
    input  logic             ack_pin,
    output logic             s_q,
    output logic             x_q,
    output logic             i_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= CCR_RESET.s;
            x_q <= CCR_RESET.x;
            i_q <= CCR_RESET.i;
        end else begin
            if (src == SRC_TAP || src == SRC_RTI) begin
                s_q <= sw_data[7];
                x_q <= x_q & sw_data[6];
                i_q <= sw_data[4];
            end
            if (ack_valid) begin
                i_q <= 1'b1;
                if (ack_pin) x_q <= 1'b1;
            end
        end
    end

    // R5
    x_no_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!x_q && !(ack_valid && ack_pin)) |=> !x_q);
    // R3
    ack_sets_i_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> i_q);
    // R4
    ack_pin_sets_x_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_pin) |=> (x_q && i_q));
    // R1
    reset_masks_chk: assert property (@(posedge clk)
        rst |=> (s_q && x_q && i_q));
endmodule

// File: rtl/ccr_arb.sv
module ccr_arb (
    input  logic irq_pend,
    input  logic xirq_pend,
    input  logic i_mask,
    input  logic x_mask,
    output logic take_irq,
    output logic take_xirq
);
    always_comb begin
        take_xirq = xirq_pend & ~x_mask;
        take_irq  = irq_pend & ~i_mask & ~take_xirq;
    end
endmodule

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_upd,
    input  logic [FLAG_W-1:0] alu_nzvc,
    input  logic              add_op,
    input  logic [OPND_W-1:0] add_a,
    input  logic [OPND_W-1:0] add_b,
    input  logic              add_cin,
    input  logic              tap_we,
    input  logic [CCR_W-1:0]  tap_data,
    input  logic              rti_we,
    input  logic [CCR_W-1:0]  rti_data,
    input  logic              irq_pend,
    input  logic              xirq_pend,
    input  logic              ack_valid,
    input  logic              ack_pin,
    input  logic              stop_dec,
    output logic [CCR_W-1:0]  ccr_q,
    output logic              take_irq,
    output logic              take_xirq,
    output logic              stop_ok
);
    wsrc_e             src;
    logic [CCR_W-1:0]  sw_data;
    logic              s_q, x_q, i_q, h_q;
    logic [FLAG_W-1:0] nzvc_q;
    ccr_t              ccr;

    always_comb begin
        if (rti_we) begin
            src     = SRC_RTI;
            sw_data = rti_data;
        end else if (tap_we) begin
            src     = SRC_TAP;
            sw_data = tap_data;
        end else begin
            src     = (alu_upd || add_op) ? SRC_ALU : SRC_NONE;
            sw_data = '0;
        end
    end

    ccr_flags i_flags (
        .clk(clk), .rst(rst), .src(src), .add_op(add_op), .add_a(add_a),
        .add_b(add_b), .add_cin(add_cin), .alu_upd(alu_upd),
        .alu_nzvc(alu_nzvc), .sw_data(sw_data), .h_q(h_q), .nzvc_q(nzvc_q)
    );

    ccr_mask i_mask (
        .clk(clk), .rst(rst), .src(src), .sw_data(sw_data),
        .ack_valid(ack_valid), .ack_pin(ack_pin),
        .s_q(s_q), .x_q(x_q), .i_q(i_q)
    );

    ccr_arb i_arb (
        .irq_pend(irq_pend), .xirq_pend(xirq_pend), .i_mask(i_q),
        .x_mask(x_q), .take_irq(take_irq), .take_xirq(take_xirq)
    );

    always_comb begin
        ccr   = '{s: s_q, x: x_q, h: h_q, i: i_q,
                  n: nzvc_q[3], z: nzvc_q[2], v: nzvc_q[1], c: nzvc_q[0]};
        ccr_q = ccr;
    end

    assign stop_ok = stop_dec & ~s_q;

    // R2
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ccr_q[4] |-> !take_irq);
    // R10
    take_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({take_irq, take_xirq}));
    // R11
    stop_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        ccr_q[7] |-> !stop_ok);
endmodule

// File: tb/test_ccr_ctrl.sv
module test_ccr_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alu_upd = 0, add_op = 0, add_cin = 0, tap_we = 0, rti_we = 0;
    logic [3:0] alu_nzvc = 0;
    logic [7:0] add_a = 0, add_b = 0, tap_data = 0, rti_data = 0;
    logic irq_pend = 0, xirq_pend = 0, ack_valid = 0, ack_pin = 0, stop_dec = 0;
    logic [7:0] ccr_q;
    logic take_irq, take_xirq, stop_ok;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ccr_ctrl i_ccr_ctrl (
        .clk(clk), .rst(rst), .alu_upd(alu_upd), .alu_nzvc(alu_nzvc),
        .add_op(add_op), .add_a(add_a), .add_b(add_b), .add_cin(add_cin),
        .tap_we(tap_we), .tap_data(tap_data), .rti_we(rti_we),
        .rti_data(rti_data), .irq_pend(irq_pend), .xirq_pend(xirq_pend),
        .ack_valid(ack_valid), .ack_pin(ack_pin), .stop_dec(stop_dec),
        .ccr_q(ccr_q), .take_irq(take_irq), .take_xirq(take_xirq),
        .stop_ok(stop_ok)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1; step; rst = 0;
    endtask

    task automatic idle;
        alu_upd = 0; add_op = 0; tap_we = 0; rti_we = 0; ack_valid = 0; ack_pin = 0;
    endtask

    task automatic tap(input logic [7:0] v);
        tap_we = 1; tap_data = v; step; tap_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step; do_reset;
        // R1 reset value
        chk("R1", ccr_q, 8'hD0);

        // R6 and R5: every transfer value, then 0xFF on top
        for (int v = 0; v < 256; v++) begin
            do_reset;
            tap(8'(v));
            chk("R6", ccr_q, 8'(v));
            tap(8'hFF);
            chk("R5", ccr_q, v[6] ? 8'hFF : 8'hBF);
        end

        // R7 restore follows the same rule
        for (int v = 0; v < 256; v += 17) begin
            do_reset;
            tap(8'h00);
            rti_we = 1; rti_data = 8'(v); step; rti_we = 0;
            chk("R7", ccr_q, 8'(v) & 8'hBF);
        end

        // R8 half-carry sweep
        do_reset;
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int c = 0; c < 2; c++) begin
                    add_op = 1; add_a = 8'((b << 4) | a); add_b = 8'((a << 4) | b);
                    add_cin = c[0]; step; add_op = 0;
                    chk("R8", {7'b0, ccr_q[5]}, (a + b + c > 15) ? 8'd1 : 8'd0);
                end

        // R9 NZVC load
        for (int v = 0; v < 16; v++) begin
            do_reset;
            alu_upd = 1; alu_nzvc = 4'(v); step; alu_upd = 0;
            chk("R9", ccr_q, 8'hD0 | 8'(v));
        end

        // R2, R10, R11: all mask and request combinations
        for (int m = 0; m < 16; m++) begin
            logic xm, im, ip, xp;
            {xm, im, ip, xp} = 4'(m);
            do_reset;
            tap({1'b0, xm, 1'b0, im, 4'b0});
            irq_pend = ip; xirq_pend = xp; stop_dec = 1;
            #1;
            chk("R10", {7'b0, take_xirq}, {7'b0, xp & ~xm});
            chk("R2",  {7'b0, take_irq},  {7'b0, ip & ~im & ~(xp & ~xm)});
            chk("R11", {7'b0, stop_ok}, 8'd1);
            irq_pend = 0; xirq_pend = 0; stop_dec = 0;
        end
        do_reset;
        stop_dec = 1; #1;
        chk("R11", {7'b0, stop_ok}, 8'd0);
        stop_dec = 0;

        // R3 maskable acknowledge
        do_reset; tap(8'h00);
        ack_valid = 1; ack_pin = 0; step; idle;
        chk("R3", ccr_q, 8'h10);
        // R4 pin acknowledge
        tap(8'h00);
        ack_valid = 1; ack_pin = 1; step; idle;
        chk("R4", ccr_q, 8'h50);

        // R12 priorities
        do_reset; tap(8'h00);
        rti_we = 1; rti_data = 8'h2A; tap_we = 1; tap_data = 8'h85; step; idle;
        chk("R12", ccr_q, 8'h2A);
        tap_we = 1; tap_data = 8'h03; alu_upd = 1; alu_nzvc = 4'hC; step; idle;
        chk("R12", ccr_q, 8'h03);
        tap_we = 1; tap_data = 8'h00; ack_valid = 1; ack_pin = 1; step; idle;
        chk("R12", ccr_q, 8'h50);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule